// File: doc/BRIEF.md
# Dirty Page Write Logger

This block observes guest write transactions. Each transaction carries a guest physical address and the current dirty flag of the page's translation entry. When a write lands on a page whose dirty flag is still clear, the block issues a dirty-flag update for that page. If logging is enabled, it also stores the page-aligned address as a 64-bit record in a log buffer in memory. Writes to pages that are already dirty pass through without any effect.

The log buffer holds `ENTRIES` records of 8 bytes each. It begins at a software-programmed base address, and the block aligns that base to the buffer size. Records are placed from the top of the buffer downward. A software-loaded index selects the slot: the record goes to byte address base + (index − 1) × 8, and the index then drops by one. When the last slot is used the block raises a held full event, and it never wraps. Software drains the buffer and reloads the index. That reload clears the event, and logging resumes from the new index.

Each record is written through a valid/ready memory port. While a record is outstanding, the observation input is stalled so that no clean-to-dirty transition is missed.

Top module: `dirty_page_logger`

## Requirements
- R1: After reset, `obsReady` is 1, `memValid`, `dUpdValid`, `fullEvent` and `logEnable` are 0, `logBase` is 0 and `logIndex` equals `ENTRIES`.
- R2: A write accepted (`obsValid` and `obsReady` high at a clock edge) with `obsDirty` = 0 gives, in the next cycle only, `dUpdValid` = 1 with `dUpdGpa` equal to `obsGpa` with its low `PAGE_BITS` (12) bits cleared. This holds whatever the enable state.
- R3: Such a write, accepted while `logEnable` = 1 and `logIndex` ≠ 0, raises `memValid` in the next cycle. `memAddr` is `logBase` + (`logIndex` − 1) × 8 and `memData` is the page-aligned address, zero-extended to 64 bits.
- R4: `memValid` is held with `memAddr` and `memData` unchanged until a clock edge with `memReady` = 1. `obsReady` is 0 for as long as `memValid` is 1.
- R5: At the edge where `memValid` and `memReady` are both 1, `memValid` falls and `logIndex` decreases by one.
- R6: The handshake that takes `logIndex` from 1 to 0 sets `fullEvent` in the next cycle.
- R7: A loggable clean write accepted while `logIndex` = 0 issues no memory write and sets `fullEvent`. `fullEvent` then stays 1 until software writes the index.
- R8: An index write (`swIdxWe`) loads `logIndex` from `swIdxData` and clears `fullEvent` in the next cycle. At the same edge it takes priority over a decrement and over setting the event.
- R9: While `logEnable` = 0, clean writes still produce dirty-flag updates, but no memory write occurs and `fullEvent` is not set.
- R10: `swBaseWe` stores `swBaseData` with its low log2(`ENTRIES` × 8) bits cleared into `logBase`. `swEnWe` stores `swEnData` into `logEnable`. A base change after a record has been launched does not alter that record's address.
- R11: An accepted write with `obsDirty` = 1 produces no dirty-flag update, no memory write and no index change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| obsValid | input | 1 | Observed write present |
| obsReady | output | 1 | Block can accept an observed write |
| obsGpa | input | ADDR_W | Guest physical address of the write |
| obsDirty | input | 1 | Current dirty flag of the page |
| dUpdValid | output | 1 | One-cycle strobe: set the page's dirty flag |
| dUpdGpa | output | ADDR_W | Page-aligned address for the dirty-flag update |
| memValid | output | 1 | Log record write request |
| memReady | input | 1 | Memory accepts the record |
| memAddr | output | ADDR_W | Byte address of the record |
| memData | output | 64 | Record contents |
| swBaseWe | input | 1 | Software write strobe for the base register |
| swBaseData | input | ADDR_W | New base address |
| swIdxWe | input | 1 | Software write strobe for the index register |
| swIdxData | input | IDX_W | New index value |
| swEnWe | input | 1 | Software write strobe for the enable bit |
| swEnData | input | 1 | New enable value |
| logBase | output | ADDR_W | Current aligned base |
| logIndex | output | IDX_W | Current index |
| logEnable | output | 1 | Current enable bit |
| fullEvent | output | 1 | Buffer-full exit event, held |

## Verification
The bench builds the block with `ENTRIES` = 8 and `ADDR_W` = 40. The small buffer lets a full fill, the index-zero case and a reload be reached in a few dozen transactions. The 64-byte alignment makes base masking visible in a single byte. The bench drives memory readiness in three ways: always ready, pseudo-random, and held low. Held-low readiness keeps records pending so that a base change and an index reload can land while a record is in flight.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

  typedef struct packed {
    logic cleanAccept;  // clean page write taken this cycle
    logic launchRec;    // a record write starts
    logic recDone;      // record write handshake completes
  } dplStrobes_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } dplState_t;

endpackage

// File: rtl/dpl_ctrl.sv
module dpl_ctrl
  import dpl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        obsValid,
  input  logic        obsDirty,
  input  logic        logEnable,
  input  logic        idxZero,
  input  logic        idxOne,
  input  logic        memReady,
  input  logic        swIdxWe,
  output logic        obsReady,
  output logic        memValid,
  output logic        fullEvent,
  output dplStrobes_t strobes
);

  dplState_t state, stateNext;
  logic      fullNext;
  logic      setFull;

  always_comb begin
    obsReady            = (state == ST_IDLE);
    memValid            = (state == ST_WRITE);
    strobes.cleanAccept = obsValid && obsReady && !obsDirty;
    strobes.launchRec   = strobes.cleanAccept && logEnable && !idxZero;
    strobes.recDone     = memValid && memReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobes.launchRec) stateNext = ST_WRITE;
      ST_WRITE: if (strobes.recDone)   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    setFull = (strobes.recDone && idxOne) ||
              (strobes.cleanAccept && logEnable && idxZero);
    fullNext = fullEvent;
    if (swIdxWe)      fullNext = 1'b0;
    else if (setFull) fullNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fullEvent <= 1'b0;
    end else begin
      state     <= stateNext;
      fullEvent <= fullNext;
    end
  end

endmodule

// File: rtl/dpl_datapath.sv
module dpl_datapath
  import dpl_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int ENTRIES   = 512,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(ENTRIES) + 1,
  localparam int REC_SHIFT = 3,
  localparam int BUF_BITS = $clog2(ENTRIES) + REC_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  dplStrobes_t       strobes,
  input  logic [ADDR_W-1:0] obsGpa,
  input  logic              swBaseWe,
  input  logic [ADDR_W-1:0] swBaseData,
  input  logic              swIdxWe,
  input  logic [IDX_W-1:0]  swIdxData,
  input  logic              swEnWe,
  input  logic              swEnData,
  output logic              idxZero,
  output logic              idxOne,
  output logic [ADDR_W-1:0] logBase,
  output logic [IDX_W-1:0]  logIndex,
  output logic              logEnable,
  output logic              dUpdValid,
  output logic [ADDR_W-1:0] dUpdGpa,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memData
);

  logic [ADDR_W-1:0] pageAddr;
  logic [IDX_W-1:0]  idxMinus1;
  logic [ADDR_W-1:0] slotOffset;
  logic [ADDR_W-1:0] slotAddr;

  always_comb begin
    pageAddr   = {obsGpa[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    idxMinus1  = logIndex - IDX_W'(1);
    slotOffset = ADDR_W'(idxMinus1) << REC_SHIFT;
    slotAddr   = logBase + slotOffset;
    idxZero    = (logIndex == '0);
    idxOne     = (logIndex == IDX_W'(1));
  end

  // software registers and index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logBase   <= '0;
      logIndex  <= IDX_W'(ENTRIES);
      logEnable <= 1'b0;
    end else begin
      if (swBaseWe)
        logBase <= {swBaseData[ADDR_W-1:BUF_BITS], {BUF_BITS{1'b0}}};
      if (swEnWe)
        logEnable <= swEnData;
      if (swIdxWe)
        logIndex <= swIdxData;
      else if (strobes.recDone)
        logIndex <= idxMinus1;
    end
  end

  // dirty-flag update strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dUpdValid <= 1'b0;
      dUpdGpa   <= '0;
    end else begin
      dUpdValid <= strobes.cleanAccept;
      if (strobes.cleanAccept)
        dUpdGpa <= pageAddr;
    end
  end

  // record captured at launch, held until handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memData <= '0;
    end else if (strobes.launchRec) begin
      memAddr                <= slotAddr;
      memData                <= '0;
      memData[ADDR_W-1:0]    <= pageAddr;
    end
  end

endmodule

// File: rtl/dirty_page_logger.sv
module dirty_page_logger
  import dpl_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int ENTRIES   = 512,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(ENTRIES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              obsValid,
  output logic              obsReady,
  input  logic [ADDR_W-1:0] obsGpa,
  input  logic              obsDirty,
  output logic              dUpdValid,
  output logic [ADDR_W-1:0] dUpdGpa,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memData,
  input  logic              swBaseWe,
  input  logic [ADDR_W-1:0] swBaseData,
  input  logic              swIdxWe,
  input  logic [IDX_W-1:0]  swIdxData,
  input  logic              swEnWe,
  input  logic              swEnData,
  output logic [ADDR_W-1:0] logBase,
  output logic [IDX_W-1:0]  logIndex,
  output logic              logEnable,
  output logic              fullEvent
);

  dplStrobes_t strobes;
  logic        idxZero;
  logic        idxOne;

  dpl_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .obsValid  (obsValid),
    .obsDirty  (obsDirty),
    .logEnable (logEnable),
    .idxZero   (idxZero),
    .idxOne    (idxOne),
    .memReady  (memReady),
    .swIdxWe   (swIdxWe),
    .obsReady  (obsReady),
    .memValid  (memValid),
    .fullEvent (fullEvent),
    .strobes   (strobes)
  );

  dpl_datapath #(
    .ADDR_W    (ADDR_W),
    .ENTRIES   (ENTRIES),
    .PAGE_BITS (PAGE_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .obsGpa     (obsGpa),
    .swBaseWe   (swBaseWe),
    .swBaseData (swBaseData),
    .swIdxWe    (swIdxWe),
    .swIdxData  (swIdxData),
    .swEnWe     (swEnWe),
    .swEnData   (swEnData),
    .idxZero    (idxZero),
    .idxOne     (idxOne),
    .logBase    (logBase),
    .logIndex   (logIndex),
    .logEnable  (logEnable),
    .dUpdValid  (dUpdValid),
    .dUpdGpa    (dUpdGpa),
    .memAddr    (memAddr),
    .memData    (memData)
  );

endmodule

// File: rtl/dpl_checker.sv
module dpl_checker #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              obsValid,
  input logic              obsReady,
  input logic              obsDirty,
  input logic              dUpdValid,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [63:0]       memData,
  input logic              swIdxWe,
  input logic [IDX_W-1:0]  logIndex,
  input logic              logEnable,
  input logic              fullEvent
);

  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !obsReady); // R4

  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData))); // R4

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !swIdxWe) |=> (logIndex == $past(logIndex) - IDX_W'(1))); // R5

  AST_HANDSHAKE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> !memValid); // R5

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fullEvent && !swIdxWe) |=> fullEvent); // R7

  AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    swIdxWe |=> !fullEvent); // R8

  AST_CLEAN_UPDATES: assert property (@(posedge clk) disable iff (!rstN)
    (obsValid && obsReady && !obsDirty) |=> dUpdValid); // R2

  AST_DIRTY_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (obsValid && obsReady && obsDirty) |=> (!dUpdValid && !memValid)); // R11

  AST_DISABLED_NO_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (obsValid && obsReady && !logEnable) |=> !memValid); // R9

endmodule

bind dirty_page_logger dpl_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .obsValid  (obsValid),
  .obsReady  (obsReady),
  .obsDirty  (obsDirty),
  .dUpdValid (dUpdValid),
  .memValid  (memValid),
  .memReady  (memReady),
  .memAddr   (memAddr),
  .memData   (memData),
  .swIdxWe   (swIdxWe),
  .logIndex  (logIndex),
  .logEnable (logEnable),
  .fullEvent (fullEvent)
);

// File: tb/sim_dirty_page_logger.sv
`timescale 1ns/100ps
module sim_dirty_page_logger;

  localparam int AW   = 40;
  localparam int ENT  = 8;
  localparam int IW   = $clog2(ENT) + 1;
  localparam int BUFB = $clog2(ENT) + 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          obsValid = 1'b0;
  logic          obsReady;
  logic [AW-1:0] obsGpa = '0;
  logic          obsDirty = 1'b0;
  logic          dUpdValid;
  logic [AW-1:0] dUpdGpa;
  logic          memValid;
  logic          memReady = 1'b0;
  logic [AW-1:0] memAddr;
  logic [63:0]   memData;
  logic          swBaseWe = 1'b0;
  logic [AW-1:0] swBaseData = '0;
  logic          swIdxWe = 1'b0;
  logic [IW-1:0] swIdxData = '0;
  logic          swEnWe = 1'b0;
  logic          swEnData = 1'b0;
  logic [AW-1:0] logBase;
  logic [IW-1:0] logIndex;
  logic          logEnable;
  logic          fullEvent;

  always #2.5 clk = ~clk;

  dirty_page_logger #(.ADDR_W(AW), .ENTRIES(ENT), .PAGE_BITS(12)) u0 (
    .clk(clk), .rstN(rstN), .obsValid(obsValid), .obsReady(obsReady),
    .obsGpa(obsGpa), .obsDirty(obsDirty), .dUpdValid(dUpdValid),
    .dUpdGpa(dUpdGpa), .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memData(memData), .swBaseWe(swBaseWe),
    .swBaseData(swBaseData), .swIdxWe(swIdxWe), .swIdxData(swIdxData),
    .swEnWe(swEnWe), .swEnData(swEnData), .logBase(logBase),
    .logIndex(logIndex), .logEnable(logEnable), .fullEvent(fullEvent)
  );

  int  nChecks = 0;
  int  nBad = 0;
  int  cycles = 0;
  int  handshakes = 0;
  bit  done = 1'b0;
  int  readyMode = 0;  // 0 always, 1 pseudo-random, 2 held low
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  longint mBase = 0;
  int     mIdx = ENT;
  bit     mEn = 0, mFull = 0, mMemValid = 0, mUpd = 0;
  longint mAddr = 0, mData = 0, mUpdGpa = 0;

  always @(posedge clk) begin
    longint page;
    bit acc, done1;
    int nIdx;
    bit nFull;
    if (!rstN) begin
      mBase = 0; mIdx = ENT; mEn = 0; mFull = 0; mMemValid = 0; mUpd = 0;
    end else begin
      page  = longint'(obsGpa) & ~longint'(12'hFFF);
      acc   = obsValid && !mMemValid;
      done1 = mMemValid && memReady;
      nIdx  = mIdx;
      nFull = mFull;
      mUpd  = 0;
      if (done1) begin
        mMemValid = 0;
        nIdx = mIdx - 1;
        if (mIdx == 1) nFull = 1;
      end
      if (acc && !obsDirty) begin
        mUpd = 1;
        mUpdGpa = page;
        if (mEn) begin
          if (mIdx != 0) begin
            mMemValid = 1;
            mAddr = (mBase + longint'(mIdx - 1) * 8) & ((longint'(1) << AW) - 1);
            mData = page;
          end else nFull = 1;
        end
      end
      if (swBaseWe) mBase = (longint'(swBaseData) >> BUFB) << BUFB;
      if (swEnWe)   mEn = swEnData;
      if (swIdxWe) begin nIdx = int'(swIdxData); nFull = 0; end
      mIdx  = nIdx;
      mFull = nFull;
    end
  end

  // per-cycle comparison after the edge has settled
  always @(posedge clk) begin
    if (rstN && memValid && memReady) handshakes++;
    #1;
    if (rstN && !done) begin
      chk("R4", "obsReady", obsReady, !mMemValid);
      chk("R3", "memValid", memValid, mMemValid);
      if (mMemValid) begin
        chk("R3", "memAddr", memAddr, mAddr);
        chk("R3", "memData", memData, mData);
      end
      chk("R2", "dUpdValid", dUpdValid, mUpd);
      if (mUpd) chk("R2", "dUpdGpa", dUpdGpa, mUpdGpa);
      chk("R7", "fullEvent", fullEvent, mFull);
      chk("R5", "logIndex", logIndex, mIdx);
      chk("R10", "logBase", logBase, mBase);
      chk("R10", "logEnable", logEnable, mEn);
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (readyMode)
      0: memReady <= 1'b1;
      1: memReady <= lfsr[0];
      default: memReady <= 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      nChecks++; nBad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  task automatic pageWrite(logic [AW-1:0] gpa, bit dirty);
    @(negedge clk);
    obsValid = 1'b1; obsGpa = gpa; obsDirty = dirty;
    while (!obsReady) @(negedge clk);
    @(negedge clk);
    obsValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setBase(logic [AW-1:0] v);
    @(negedge clk); swBaseWe = 1'b1; swBaseData = v;
    @(negedge clk); swBaseWe = 1'b0;
  endtask

  task automatic setIdx(int v);
    @(negedge clk); swIdxWe = 1'b1; swIdxData = IW'(v);
    @(negedge clk); swIdxWe = 1'b0;
  endtask

  task automatic setEn(bit v);
    @(negedge clk); swEnWe = 1'b1; swEnData = v;
    @(negedge clk); swEnWe = 1'b0;
  endtask

  initial begin
    int hs0;
    idle(3);
    chk("R1", "reset obsReady", obsReady, 1);
    chk("R1", "reset memValid", memValid, 0);
    chk("R1", "reset fullEvent", fullEvent, 0);
    chk("R1", "reset logIndex", logIndex, ENT);
    chk("R1", "reset logEnable", logEnable, 0);
    rstN = 1'b1;
    idle(2);

    // R11: dirty page, R9: disabled logging still updates flags
    pageWrite(40'hAB_CDEF_1234, 1'b1);
    pageWrite(40'hAB_CDEF_1234, 1'b0);
    idle(2);
    chk("R9", "no record while disabled", handshakes, 0);
    chk("R11", "index untouched", logIndex, ENT);

    // R10: base masking
    setBase(40'h12_3456_789A);
    chk("R10", "aligned base", logBase, 40'h12_3456_7880);
    setEn(1'b1);

    // R3 R5 R6: fill buffer with random memory readiness
    readyMode = 1;
    hs0 = handshakes;
    for (int i = 0; i < ENT; i++) pageWrite(AW'(40'h1000 * (i + 3) + i), 1'b0);
    while (memValid) @(negedge clk);
    idle(1);
    chk("R6", "records written", handshakes - hs0, ENT);
    chk("R6", "full after fill", fullEvent, 1);
    chk("R6", "index zero", logIndex, 0);

    // R7: loggable write at index zero
    hs0 = handshakes;
    pageWrite(40'h77_0000_5000, 1'b0);
    idle(3);
    chk("R7", "no write at zero", handshakes - hs0, 0);
    chk("R7", "full held", fullEvent, 1);

    // R8: reload clears
    setIdx(3);
    chk("R8", "full cleared", fullEvent, 0);
    chk("R8", "index loaded", logIndex, 3);

    // R10: base change while record pending; R4 hold
    readyMode = 2;
    pageWrite(40'h05_5555_5FFF, 1'b0);
    setBase(40'h20_0000_0000);
    idle(3);
    readyMode = 0;
    idle(3);

    // R8: index write collides with handshake
    readyMode = 2;
    pageWrite(40'h06_0000_1000, 1'b0);
    @(negedge clk);
    readyMode = 0;
    swIdxWe = 1'b1; swIdxData = IW'(5);
    @(negedge clk);
    swIdxWe = 1'b0;
    idle(2);
    chk("R8", "write wins over decrement", logIndex, 5);

    // R6 via index 1 and R2 mixed stream
    setIdx(1);
    pageWrite(40'h09_0000_2abc, 1'b1);
    pageWrite(40'h09_0000_3abc, 1'b0);
    idle(2);
    chk("R6", "full from last slot", fullEvent, 1);

    // R9: disable keeps full from being set
    setIdx(0);
    setEn(1'b0);
    pageWrite(40'h0A_0000_4000, 1'b0);
    idle(2);
    chk("R9", "no full while disabled", fullEvent, 0);

    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule